// File: doc/BRIEF.md
# Spare-Area Status Stripper and Read Classifier

After a page read, an ECC engine hands back the spare area of the page with four extra status bytes inserted after each chunk's out-of-band bytes. This block sits in that byte stream. It forwards every out-of-band byte unchanged and in order, so that the downstream consumer sees one contiguous out-of-band stream. It swallows the four status bytes of each chunk. The first status byte of each chunk is decoded into one of four classes: clean, erased, corrected (carrying the flip count) or uncorrectable. The block keeps three page-level figures: the sum of corrected bits, the largest correction in any chunk, and the number of failed chunks.

Software or a sequencer pulses `start` with the chunk count and the per-chunk out-of-band length. The block samples both values at that pulse. It then consumes exactly `chunkCountIn` records of `oobStepIn + 4` bytes each. One cycle after the last byte is taken, `done` pulses and the figures are final. The correction itself happens elsewhere.

Top module: `spare_status_strip`

## Requirements
- R1: After reset `inReady`, `outValid` and `done` are low and `totalFlips`, `maxFlips` and `failCount` are zero, even if `inValid` is high.
- R2: A `start` pulse clears all three figures and samples `oobStepIn` and `chunkCountIn`. Changes to those inputs during the page have no effect.
- R3: The first `oobStepIn` bytes of each record are forwarded in order on `outData`. The output stream holds only these bytes, so chunk n's bytes follow directly after chunk n-1's. `outValid` follows `inValid` and `inReady` follows `outReady` for these bytes.
- R4: The four bytes after each chunk's out-of-band bytes never appear on the output. They are accepted (`inReady` high) whatever `outReady` is.
- R5: A first status byte of 0x00 (clean) changes no figure.
- R6: A first status byte of 0xFF (erased) changes no figure.
- R7: A first status byte of 0xFE, or any value from 0x29 to 0xFD, increments `failCount`. `pageFail` is high whenever `failCount` is non-zero.
- R8: A first status byte from 0x01 to 0x28 is added to `totalFlips` and raises `maxFlips` if it is larger.
- R9: `done` is high for exactly one cycle, in the cycle after the last byte of the last chunk is accepted. From then until the next `start`, `inReady` is low and the figures hold.
- R10: The second, third and fourth status bytes of a record do not affect any figure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a page: clear figures, sample configuration |
| oobStepIn | input | OOB_W | Out-of-band bytes per chunk (at least 1) |
| chunkCountIn | input | CHUNK_W | Chunks per page (at least 1) |
| inValid | input | 1 | Spare stream byte valid |
| inData | input | 8 | Spare stream byte |
| inReady | output | 1 | Spare stream byte accepted |
| outValid | output | 1 | Rebuilt out-of-band byte valid |
| outData | output | 8 | Rebuilt out-of-band byte |
| outReady | input | 1 | Consumer accepts the out-of-band byte |
| done | output | 1 | One-cycle end-of-page pulse |
| pageFail | output | 1 | At least one chunk was uncorrectable |
| maxFlips | output | 6 | Largest per-chunk correction this page |
| totalFlips | output | CHUNK_W+6 | Sum of corrected bits this page |
| failCount | output | CHUNK_W | Uncorrectable chunks this page |

## Verification
All 256 status codes are placed as first status bytes over a run of four-chunk pages. This separates the clean and erased codes from the corrected range, from 0xFE and from the codes above 0x28, and catches off-by-one bounds at 0x28 and 0x29. Each trailing status byte carries a failing, a correcting or a varying code, so a block that decodes the wrong byte gives wrong figures. A second sweep crosses out-of-band lengths 1 to 5 with chunk counts 1 to 4 while the consumer throttles `outReady`. It compares the rebuilt stream byte for byte, which exposes a wrong record length, a leaked status byte or a dropped byte under backpressure. Each page also changes the configuration inputs after `start`, which shows whether the sampled values are used.

// File: rtl/spare_pkg.sv
package spare_pkg;

  typedef enum logic [1:0] {
    CLS_CLEAN,
    CLS_ERASED,
    CLS_FIXED,
    CLS_BAD
  } statClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;       // start of page
    logic statusTake;  // first status byte of a record accepted
    logic pageEnd;     // last byte of the last record accepted
  } ctlStrobe_t;

  localparam logic [7:0] CODE_CLEAN  = 8'h00;
  localparam logic [7:0] CODE_ERASED = 8'hFF;
  localparam logic [7:0] CODE_BAD    = 8'hFE;
  localparam logic [7:0] CODE_MAXFIX = 8'h28;
  localparam int STATUS_BYTES = 4;
  localparam int FLIP_W = 6;

  function automatic statClass_e classify(input logic [7:0] code);
    if (code == CODE_CLEAN)                          return CLS_CLEAN;
    else if (code == CODE_ERASED)                    return CLS_ERASED;
    else if (code == CODE_BAD || code > CODE_MAXFIX) return CLS_BAD;
    else                                             return CLS_FIXED;
  endfunction

endpackage

// File: rtl/spare_ctl.sv
module spare_ctl
  import spare_pkg::*;
#(
  parameter int OOB_W   = 8,
  parameter int CHUNK_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [OOB_W-1:0]   oobStepIn,
  input  logic [CHUNK_W-1:0] chunkCountIn,
  input  logic               inValid,
  output logic               inReady,
  output logic               outValid,
  input  logic               outReady,
  output ctlStrobe_t         strobe
);

  localparam int POS_W = OOB_W + 1;

  logic               active;
  logic [POS_W-1:0]   pos;
  logic [CHUNK_W-1:0] chunkIdx;
  logic [OOB_W-1:0]   oobStepQ;
  logic [CHUNK_W-1:0] chunkCntQ;

  logic [POS_W-1:0] statusFirst;
  logic [POS_W-1:0] statusLast;
  logic             inStatus;
  logic             accept;
  logic             recordEnd;
  logic             lastChunk;

  assign statusFirst = {1'b0, oobStepQ};
  assign statusLast  = statusFirst + POS_W'(STATUS_BYTES - 1);
  assign inStatus    = (pos >= statusFirst);
  assign lastChunk   = (chunkIdx == chunkCntQ - CHUNK_W'(1));

  assign inReady  = active && (inStatus || outReady);
  assign outValid = active && !inStatus && inValid;
  assign accept   = inValid && inReady;
  assign recordEnd = accept && (pos == statusLast);

  always_comb begin
    strobe            = '0;
    strobe.clear      = start;
    strobe.statusTake = !start && accept && (pos == statusFirst);
    strobe.pageEnd    = !start && recordEnd && lastChunk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      pos       <= '0;
      chunkIdx  <= '0;
      oobStepQ  <= '0;
      chunkCntQ <= '0;
    end else if (start) begin
      active    <= 1'b1;
      pos       <= '0;
      chunkIdx  <= '0;
      oobStepQ  <= oobStepIn;
      chunkCntQ <= chunkCountIn;
    end else if (accept) begin
      if (recordEnd) begin
        pos      <= '0;
        chunkIdx <= chunkIdx + CHUNK_W'(1);
        if (lastChunk) active <= 1'b0;
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/spare_dp.sv
module spare_dp
  import spare_pkg::*;
#(
  parameter int CHUNK_W = 4,
  parameter int TOTAL_W = CHUNK_W + FLIP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [7:0]         statusByte,
  output logic               done,
  output logic               pageFail,
  output logic [FLIP_W-1:0]  maxFlips,
  output logic [TOTAL_W-1:0] totalFlips,
  output logic [CHUNK_W-1:0] failCount
);

  statClass_e       cls;
  logic [FLIP_W-1:0] flips;

  assign cls      = classify(statusByte);
  assign flips    = statusByte[FLIP_W-1:0];
  assign pageFail = (failCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done       <= 1'b0;
      maxFlips   <= '0;
      totalFlips <= '0;
      failCount  <= '0;
    end else begin
      done <= strobe.pageEnd;
      if (strobe.clear) begin
        maxFlips   <= '0;
        totalFlips <= '0;
        failCount  <= '0;
      end else if (strobe.statusTake) begin
        unique case (cls)
          CLS_FIXED: begin
            totalFlips <= totalFlips + TOTAL_W'(flips);
            if (flips > maxFlips) maxFlips <= flips;
          end
          CLS_BAD: failCount <= failCount + CHUNK_W'(1);
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spare_status_strip.sv
module spare_status_strip
  import spare_pkg::*;
#(
  parameter int OOB_W   = 8,
  parameter int CHUNK_W = 4,
  localparam int TOTAL_W = CHUNK_W + FLIP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [OOB_W-1:0]   oobStepIn,
  input  logic [CHUNK_W-1:0] chunkCountIn,
  input  logic               inValid,
  input  logic [7:0]         inData,
  output logic               inReady,
  output logic               outValid,
  output logic [7:0]         outData,
  input  logic               outReady,
  output logic               done,
  output logic               pageFail,
  output logic [FLIP_W-1:0]  maxFlips,
  output logic [TOTAL_W-1:0] totalFlips,
  output logic [CHUNK_W-1:0] failCount
);

  ctlStrobe_t strobe;

  assign outData = inData;

  spare_ctl #(.OOB_W(OOB_W), .CHUNK_W(CHUNK_W)) i_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .oobStepIn    (oobStepIn),
    .chunkCountIn (chunkCountIn),
    .inValid      (inValid),
    .inReady      (inReady),
    .outValid     (outValid),
    .outReady     (outReady),
    .strobe       (strobe)
  );

  spare_dp #(.CHUNK_W(CHUNK_W), .TOTAL_W(TOTAL_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .statusByte (inData),
    .done       (done),
    .pageFail   (pageFail),
    .maxFlips   (maxFlips),
    .totalFlips (totalFlips),
    .failCount  (failCount)
  );

endmodule

// File: rtl/spare_status_chk.sv
module spare_status_chk #(
  parameter int CHUNK_W = 4,
  parameter int TOTAL_W = CHUNK_W + 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               inValid,
  input logic               inReady,
  input logic               outValid,
  input logic               done,
  input logic [5:0]         maxFlips,
  input logic [TOTAL_W-1:0] totalFlips,
  input logic [CHUNK_W-1:0] failCount
);

  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inValid); // R3

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (totalFlips == '0 && failCount == '0 && maxFlips == '0)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !inReady); // R9

  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> ($stable(totalFlips) && $stable(failCount) && $stable(maxFlips))); // R9

  AST_FAIL_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> failCount >= $past(failCount)); // R7

  AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    maxFlips <= 6'd40); // R8

  AST_MAX_LE_TOTAL: assert property (@(posedge clk) disable iff (!rstN)
    TOTAL_W'(maxFlips) <= totalFlips); // R8

endmodule

bind spare_status_strip spare_status_chk #(.CHUNK_W(CHUNK_W), .TOTAL_W(TOTAL_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .inValid    (inValid),
  .inReady    (inReady),
  .outValid   (outValid),
  .done       (done),
  .maxFlips   (maxFlips),
  .totalFlips (totalFlips),
  .failCount  (failCount)
);

// File: tb/test_spare_status_strip.sv
module test_spare_status_strip;

  localparam int OOB_W = 8;
  localparam int CHUNK_W = 4;
  localparam int TOTAL_W = CHUNK_W + 6;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [OOB_W-1:0]   oobStepIn = '0;
  logic [CHUNK_W-1:0] chunkCountIn = '0;
  logic               inValid = 1'b0;
  logic [7:0]         inData = '0;
  logic               inReady;
  logic               outValid;
  logic [7:0]         outData;
  logic               outReady = 1'b1;
  logic               done;
  logic               pageFail;
  logic [5:0]         maxFlips;
  logic [TOTAL_W-1:0] totalFlips;
  logic [CHUNK_W-1:0] failCount;

  int checks = 0;
  int errors = 0;
  int stallCnt = 0;
  int statv [16];
  logic [7:0] gotQ [$];

  always #2 clk = ~clk;  // 250 MHz

  spare_status_strip #(.OOB_W(OOB_W), .CHUNK_W(CHUNK_W)) i_spare_status_strip (
    .clk, .rstN, .start, .oobStepIn, .chunkCountIn, .inValid, .inData,
    .inReady, .outValid, .outData, .outReady, .done, .pageFail,
    .maxFlips, .totalFlips, .failCount
  );

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit stall);
    bit acc = 1'b0;
    inValid = 1'b1;
    inData = b;
    while (!acc) begin
      outReady = stall ? ((stallCnt % 3) != 0) : 1'b1;
      stallCnt++;
      #1;
      if (outValid && outReady) gotQ.push_back(outData);
      acc = inReady;
      @(negedge clk);
    end
  endtask

  task automatic doStart(input int oob, input int chunks);
    @(negedge clk);
    inValid = 1'b0;
    oobStepIn = OOB_W'(oob);
    chunkCountIn = CHUNK_W'(chunks);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    oobStepIn = OOB_W'(9);       // changed after start: must be ignored (R2)
    chunkCountIn = CHUNK_W'(2);
    check(int'(totalFlips) + int'(failCount) + int'(maxFlips), 0, "R2 figures cleared by start");
  endtask

  task automatic runPage(input int oob, input int chunks, input bit stall, input int tag);
    logic [7:0] expQ [$];
    int expTotal = 0, expMax = 0, expFail = 0, mism = 0;
    gotQ.delete();
    doStart(oob, chunks);
    for (int c = 0; c < chunks; c++) begin
      for (int k = 0; k < oob; k++) begin
        logic [7:0] b = 8'((c * 37 + k * 11 + tag * 5) & 255);
        expQ.push_back(b);
        sendByte(b, stall);
      end
      sendByte(8'(statv[c]), stall);
      if (statv[c] == 0 || statv[c] == 255) begin
        // R5 / R6: clean and erased leave figures alone
      end else if (statv[c] == 254 || statv[c] > 40) begin
        expFail++;                                    // R7
      end else begin
        expTotal += statv[c];                         // R8
        if (statv[c] > expMax) expMax = statv[c];
      end
      // trailing status bytes carry codes that would matter if decoded (R10)
      sendByte(8'hFE, stall);
      sendByte(8'h05 + 8'(c), stall);
      sendByte(8'(tag & 255), stall);
    end
    // now in the cycle after the last accepted byte
    check(int'(done), 1, "R9 done after last byte");
    check(int'(totalFlips), expTotal, "R8 total corrected bits");
    check(int'(maxFlips), expMax, "R8 R10 max per chunk");
    check(int'(failCount), expFail, "R7 failed chunks");
    check(int'(pageFail), int'(expFail != 0), "R7 page failure flag");
    check(gotQ.size(), expQ.size(), "R3 R4 rebuilt stream length");
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      if (gotQ[i] != expQ[i]) mism++;
    check(mism, 0, "R3 rebuilt stream content mismatches");
    @(negedge clk);
    check(int'(done), 0, "R9 done is one cycle");
    check(int'(inReady), 0, "R9 idle after page");
    check(int'(totalFlips), expTotal, "R9 figures hold");
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    inValid = 1'b1;  // stimulus while idle must not be taken (R1)
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(int'(inReady), 0, "R1 inReady after reset");
    check(int'(outValid), 0, "R1 outValid after reset");
    check(int'(done), 0, "R1 done after reset");
    check(int'(totalFlips) + int'(maxFlips) + int'(failCount), 0, "R1 figures after reset");
    @(negedge clk);
    inValid = 1'b0;

    // sweep every status code as a first status byte, four per page
    for (int p = 0; p < 64; p++) begin
      for (int c = 0; c < 4; c++) statv[c] = 4 * p + c;
      runPage(3, 4, p[0], p);
    end

    // sweep geometry with consumer backpressure
    for (int oob = 1; oob <= 5; oob++) begin
      for (int ch = 1; ch <= 4; ch++) begin
        for (int c = 0; c < 4; c++) statv[c] = (oob * 7 + c * 13 + ch * 3) % 48;
        runPage(oob, ch, 1'b1, oob * 10 + ch);
      end
    end

    // longer chunk count, all erased then all clean
    for (int c = 0; c < 16; c++) statv[c] = 255;
    runPage(2, 15, 1'b0, 200);
    for (int c = 0; c < 16; c++) statv[c] = 0;
    runPage(2, 15, 1'b1, 201);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule